// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control state of a processor core behind one read/write port. Each access names a register by a 6-bit index. Every index has its own write rule:
- a full-width store;
- a store through a fixed field mask;
- a write that clears the register;
- read-only;
- write-only;
- unknown.

An access that breaks the rule for its index raises a fault pulse in the same cycle instead of changing state.

Three write-only indices do not store anything. They pulse a strobe toward the translation and cache logic, which lives elsewhere. One index reads back as a cycle count: its stored upper half is joined to the low bits of a free-running counter.

A speculative-path input blocks every write-side effect while it is high. That covers storage, fault and strobes. This lets the pipeline issue control writes down a path that may be squashed.

Top module: `ctrl_reg_bank`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), every register reads zero except three. Index 24 (vector base) holds parameter VEC_BASE. Index 43 (misc control) holds 0x6. Scratch index 16 holds the cpuId input, zero-extended.
- R2: Indices 0..23 (scratch), 24 and 43 store the full 64-bit write data.
- R3: Index 25 (exception return address) stores the write data with bit 1 forced to zero.
- R4: Masked indices keep only their field bits:
  - 26 and 27: 0xF
  - 28: 0x1F
  - 29 and 30: 0x18
  - 32: 0x7FFF0
  - 33: 0xFFFFFF0300
  - 34 and 35: bits 63:30
  - 36: 0x1FFB
  - 37 and 38: 0x3F
  - 39: 0x7F0
  - 40: bits 63:57
- R5: A write of any data to index 41 or 42 (exception summary/mask) leaves the register at zero.
- R6: The fault output is high when:
  - a write targets read-only index 45 or 46 (those registers stay unchanged);
  - a read targets write-only index 31, 47, 48 or 49 (rdData is then zero);
  - any access targets an index from 50 to 63.
- R7: A read of index 44 returns the stored bits 63:32 above the low 32 bits of a counter. The counter increments on every clock edge after reset.
- R8: While specIn is high, a write changes no register, raises no fault and pulses no strobe.
- R9: fault is combinational and valid in the cycle of the access. A legal access never raises it.
- R10: A non-speculative write to index 47, 48 or 49 drives flushAllStb, flushAsnStb or cacheFlushStb respectively, high for that one cycle. At most one strobe is high at a time.
- R11: rdData is combinational from regIdx and is zero whenever rdEn is low. A write shows on rdData from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuId | input | ID_W | Core identifier loaded into a scratch register at reset |
| specIn | input | 1 | Speculative-path flag; suppresses write effects |
| wrEn | input | 1 | Write request |
| rdEn | input | 1 | Read request |
| regIdx | input | 6 | Register index |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Read data, combinational |
| fault | output | 1 | Access-violation pulse |
| flushAllStb | output | 1 | Control write: flush all translations |
| flushAsnStb | output | 1 | Control write: flush per-process translations |
| cacheFlushStb | output | 1 | Control write: flush cache |

## Verification
The assertions cover several properties on every cycle:
- the speculative flag blocks both faults and strobes;
- the strobes stay mutually exclusive;
- rdData is idle when rdEn is low;
- read-only writes always fault;
- the return-address register never exposes bit 1;
- the cycle-count low word advances by one on back-to-back reads.

The exact field mask of each index, the reset values and the preserved upper half of the cycle register can only be shown by the bench's scenarios. So can the unchanged contents after rejected and speculative writes. The bench writes known patterns and compares each readback.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;

  localparam int DATA_W = 64;
  localparam int IDX_W  = 6;
  localparam int NUM_IDX = 1 << IDX_W;

  typedef enum logic [2:0] {
    K_NONE,     // unknown index
    K_FULL,     // full-width store
    K_MASK,     // store through field mask
    K_CLEAR,    // any write clears
    K_RO,       // read-only
    K_WOSTORE,  // write-only, stored
    K_STROBE,   // write-only, control pulse
    K_CYCLE     // cycle-count register
  } regKind_e;

  localparam logic [IDX_W-1:0] IX_VBASE   = 6'd24;
  localparam logic [IDX_W-1:0] IX_EXCADDR = 6'd25;
  localparam logic [IDX_W-1:0] IX_ALTMODE = 6'd31;
  localparam logic [IDX_W-1:0] IX_MISC    = 6'd43;
  localparam logic [IDX_W-1:0] IX_CYCLE   = 6'd44;
  localparam logic [IDX_W-1:0] IX_FLALL   = 6'd47;
  localparam logic [IDX_W-1:0] IX_FLASN   = 6'd48;
  localparam logic [IDX_W-1:0] IX_CFLUSH  = 6'd49;

  localparam int STB_N = 3;

  typedef struct packed {
    logic             wrCommit;  // store wrData & mask at the edge
    logic             rdGate;    // read is legal, drive data
    logic             fault;     // illegal access this cycle
    logic [STB_N-1:0] pulse;     // control-write strobes
  } ctlStb_t;

  function automatic regKind_e regKind(input logic [IDX_W-1:0] i);
    regKind_e k;
    if (i <= 6'd23) k = K_FULL;
    else begin
      case (i)
        6'd24, 6'd43:                k = K_FULL;
        6'd44:                       k = K_CYCLE;
        6'd31:                       k = K_WOSTORE;
        6'd41, 6'd42:                k = K_CLEAR;
        6'd45, 6'd46:                k = K_RO;
        6'd47, 6'd48, 6'd49:         k = K_STROBE;
        6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd30,
        6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37,
        6'd38, 6'd39, 6'd40:         k = K_MASK;
        default:                     k = K_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic logic [DATA_W-1:0] regMask(input logic [IDX_W-1:0] i);
    logic [DATA_W-1:0] m;
    case (i)
      6'd25:               m = ~64'h2;
      6'd26, 6'd27:        m = 64'hF;
      6'd28:               m = 64'h1F;
      6'd29, 6'd30, 6'd31: m = 64'h18;
      6'd32:               m = 64'h7_FFF0;
      6'd33:               m = 64'hFF_FFFF_0300;
      6'd34, 6'd35:        m = 64'hFFFF_FFFF_C000_0000;
      6'd36:               m = 64'h1FFB;
      6'd37, 6'd38:        m = 64'h3F;
      6'd39:               m = 64'h7F0;
      6'd40:               m = 64'hFE00_0000_0000_0000;
      6'd41, 6'd42:        m = '0;
      default:             m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ctrl_reg_ctrl.sv
module ctrl_reg_ctrl
  import ctrl_reg_pkg::*;
(
  input  logic             specIn,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] regIdx,
  output ctlStb_t          ctl
);

  regKind_e kind;
  logic readable;
  logic writable;
  logic wrLive;

  always_comb begin
    kind     = regKind(regIdx);
    readable = (kind == K_FULL) || (kind == K_MASK) || (kind == K_CLEAR) ||
               (kind == K_RO) || (kind == K_CYCLE);
    writable = (kind == K_FULL) || (kind == K_MASK) || (kind == K_CLEAR) ||
               (kind == K_WOSTORE) || (kind == K_STROBE) || (kind == K_CYCLE);
    wrLive   = wrEn && !specIn;

    ctl.fault    = (rdEn && !readable) || (wrLive && !writable);
    ctl.rdGate   = rdEn && readable;
    ctl.wrCommit = wrLive && writable && (kind != K_STROBE);
    ctl.pulse[0] = wrLive && (regIdx == IX_FLALL);
    ctl.pulse[1] = wrLive && (regIdx == IX_FLASN);
    ctl.pulse[2] = wrLive && (regIdx == IX_CFLUSH);
  end

endmodule

// File: rtl/ctrl_reg_datapath.sv
module ctrl_reg_datapath
  import ctrl_reg_pkg::*;
#(
  parameter logic [DATA_W-1:0] VEC_BASE = 64'h0000_0000_0000_4000,
  parameter int ID_W     = 8,
  parameter int ID_SLOT  = 16,
  parameter int CYC_LO_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   cpuId,
  input  ctlStb_t           ctl,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int HI_W = DATA_W - CYC_LO_W;

  logic [DATA_W-1:0]   stor [NUM_IDX];
  logic [CYC_LO_W-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN) cycCnt <= '0;
    else       cycCnt <= cycCnt + 1'b1;
  end

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_reg
    localparam regKind_e KIND = regKind(IDX_W'(i));
    localparam logic [DATA_W-1:0] MASK = regMask(IDX_W'(i));
    if (KIND == K_FULL || KIND == K_MASK || KIND == K_CLEAR ||
        KIND == K_WOSTORE || KIND == K_CYCLE) begin : g_store
      logic [DATA_W-1:0] rstVal;
      always_comb begin
        if (i == int'(IX_VBASE))     rstVal = VEC_BASE;
        else if (i == int'(IX_MISC)) rstVal = 64'h6;
        else if (i == ID_SLOT)       rstVal = {{(DATA_W-ID_W){1'b0}}, cpuId};
        else                         rstVal = '0;
      end
      always_ff @(posedge clk) begin
        if (!rstN)
          stor[i] <= rstVal;
        else if (ctl.wrCommit && regIdx == IDX_W'(i))
          stor[i] <= wrData & MASK;
      end
    end else begin : g_none
      assign stor[i] = '0;
    end
  end

  always_comb begin
    if (!ctl.rdGate)
      rdData = '0;
    else if (regIdx == IX_CYCLE)
      rdData = {stor[IX_CYCLE][DATA_W-1 -: HI_W], cycCnt};
    else
      rdData = stor[regIdx];
  end

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_reg_pkg::*;
#(
  parameter logic [63:0] VEC_BASE = 64'h0000_0000_0000_4000,
  parameter int ID_W     = 8,
  parameter int ID_SLOT  = 16,
  parameter int CYC_LO_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ID_W-1:0] cpuId,
  input  logic            specIn,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [5:0]      regIdx,
  input  logic [63:0]     wrData,
  output logic [63:0]     rdData,
  output logic            fault,
  output logic            flushAllStb,
  output logic            flushAsnStb,
  output logic            cacheFlushStb
);

  ctlStb_t ctl;

  ctrl_reg_ctrl u_ctrl (
    .specIn (specIn),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .regIdx (regIdx),
    .ctl    (ctl)
  );

  ctrl_reg_datapath #(
    .VEC_BASE (VEC_BASE),
    .ID_W     (ID_W),
    .ID_SLOT  (ID_SLOT),
    .CYC_LO_W (CYC_LO_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cpuId  (cpuId),
    .ctl    (ctl),
    .regIdx (regIdx),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign fault         = ctl.fault;
  assign flushAllStb   = ctl.pulse[0];
  assign flushAsnStb   = ctl.pulse[1];
  assign cacheFlushStb = ctl.pulse[2];

endmodule

// File: rtl/ctrl_reg_bank_chk.sv
module ctrl_reg_bank_chk (
  input logic        clk,
  input logic        rstN,
  input logic        specIn,
  input logic        wrEn,
  input logic        rdEn,
  input logic [5:0]  regIdx,
  input logic [63:0] rdData,
  input logic        fault,
  input logic        flushAllStb,
  input logic        flushAsnStb,
  input logic        cacheFlushStb
);

  // R8
  spec_no_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (specIn && !rdEn) |-> !fault);

  // R8
  spec_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    specIn |-> !(flushAllStb || flushAsnStb || cacheFlushStb));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flushAllStb, flushAsnStb, cacheFlushStb}));

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == 64'h0));

  // R6
  ro_write_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !specIn && (regIdx == 6'd45 || regIdx == 6'd46)) |-> fault);

  // R3
  excaddr_bit1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == 6'd25) |-> !rdData[1]);

  // R7
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == 6'd44 && $past(rdEn && regIdx == 6'd44))
      |-> (rdData[31:0] == $past(rdData[31:0]) + 32'd1));

endmodule

bind ctrl_reg_bank ctrl_reg_bank_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .specIn        (specIn),
  .wrEn          (wrEn),
  .rdEn          (rdEn),
  .regIdx        (regIdx),
  .rdData        (rdData),
  .fault         (fault),
  .flushAllStb   (flushAllStb),
  .flushAsnStb   (flushAsnStb),
  .cacheFlushStb (cacheFlushStb)
);

// File: tb/ctrl_reg_bank_test.sv
`timescale 1ns/1ps
module ctrl_reg_bank_test;

  localparam logic [63:0] VBASE = 64'h0000_0000_0000_4000;
  localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cpuId = 8'h5A;
  logic        specIn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  regIdx = '0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        fault;
  logic        flushAllStb, flushAsnStb, cacheFlushStb;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctrl_reg_bank #(.VEC_BASE(VBASE)) uut (
    .clk(clk), .rstN(rstN), .cpuId(cpuId), .specIn(specIn),
    .wrEn(wrEn), .rdEn(rdEn), .regIdx(regIdx), .wrData(wrData),
    .rdData(rdData), .fault(fault), .flushAllStb(flushAllStb),
    .flushAsnStb(flushAsnStb), .cacheFlushStb(cacheFlushStb)
  );

  typedef struct packed {
    logic [5:0]  idx;
    logic [63:0] wd;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{6'd3,  64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 4'd2}, // R2
    '{6'd24, 64'h1122_3344_5566_7788, 64'h1122_3344_5566_7788, 4'd2}, // R2
    '{6'd43, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF, 4'd2}, // R2
    '{6'd25, ONES,                    64'hFFFF_FFFF_FFFF_FFFD, 4'd3}, // R3
    '{6'd26, 64'hFF,                  64'hF,                   4'd4}, // R4
    '{6'd27, 64'h1234,                64'h4,                   4'd4}, // R4
    '{6'd28, 64'hFFFF,                64'h1F,                  4'd4}, // R4
    '{6'd29, 64'hFF,                  64'h18,                  4'd4}, // R4
    '{6'd30, 64'h08,                  64'h08,                  4'd4}, // R4
    '{6'd32, ONES,                    64'h7_FFF0,              4'd4}, // R4
    '{6'd33, ONES,                    64'hFF_FFFF_0300,        4'd4}, // R4
    '{6'd34, ONES,                    64'hFFFF_FFFF_C000_0000, 4'd4}, // R4
    '{6'd35, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_8000_0000, 4'd4}, // R4
    '{6'd36, ONES,                    64'h1FFB,                4'd4}, // R4
    '{6'd37, ONES,                    64'h3F,                  4'd4}, // R4
    '{6'd38, 64'h55,                  64'h15,                  4'd4}, // R4
    '{6'd39, ONES,                    64'h7F0,                 4'd4}, // R4
    '{6'd40, ONES,                    64'hFE00_0000_0000_0000, 4'd4}, // R4
    '{6'd41, ONES,                    64'h0,                   4'd5}, // R5
    '{6'd42, 64'h1234,                64'h0,                   4'd5}  // R5
  };

  logic        wFault;
  logic [2:0]  wStb;
  logic [63:0] rVal;
  logic        rFault;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [5:0] idx, input logic [63:0] val, input logic spec);
    @(negedge clk);
    wrEn = 1'b1; regIdx = idx; wrData = val; specIn = spec;
    #1;
    wFault = fault;
    wStb = {cacheFlushStb, flushAsnStb, flushAllStb};
    @(posedge clk);
    #1;
    wrEn = 1'b0; specIn = 1'b0;
    wStb = wStb;
  endtask

  task automatic doRead(input logic [5:0] idx);
    @(negedge clk);
    rdEn = 1'b1; regIdx = idx;
    #1;
    rVal = rdData;
    rFault = fault;
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    doRead(6'd24); check("R1", rVal, VBASE);
    doRead(6'd43); check("R1", rVal, 64'h6);
    doRead(6'd16); check("R1", rVal, 64'h5A);
    doRead(6'd0);  check("R1", rVal, 64'h0);
    doRead(6'd33); check("R1", rVal, 64'h0);

    // R11 idle read
    @(negedge clk); regIdx = 6'd24; #1;
    check("R11", rdData, 64'h0);

    // R2 R3 R4 R5 R9 table walk
    for (int k = 0; k < NV; k++) begin
      doWrite(VECS[k].idx, VECS[k].wd, 1'b0);
      check("R9", {63'h0, wFault}, 64'h0);
      doRead(VECS[k].idx);
      nRun++;
      if (rVal !== VECS[k].exp || rFault !== 1'b0) begin
        nFail++;
        $display("FAIL R%0d idx=%0d actual=%h expected=%h", VECS[k].req,
                 VECS[k].idx, rVal, VECS[k].exp);
      end
    end

    // R6 read-only write faults and leaves value
    doWrite(6'd45, ONES, 1'b0); check("R6", {63'h0, wFault}, 64'h1);
    doRead(6'd45); check("R6", rVal, 64'h0); check("R6", {63'h0, rFault}, 64'h0);
    doWrite(6'd46, ONES, 1'b0); check("R6", {63'h0, wFault}, 64'h1);
    // R6 write-only read faults
    doWrite(6'd31, ONES, 1'b0); check("R6", {63'h0, wFault}, 64'h0);
    doRead(6'd31); check("R6", {63'h0, rFault}, 64'h1); check("R6", rVal, 64'h0);
    doRead(6'd47); check("R6", {63'h0, rFault}, 64'h1);
    // R6 unknown index
    doRead(6'd55);  check("R6", {63'h0, rFault}, 64'h1);
    doWrite(6'd63, ONES, 1'b0); check("R6", {63'h0, wFault}, 64'h1);
    doWrite(6'd50, ONES, 1'b0); check("R6", {63'h0, wFault}, 64'h1);

    // R8 speculative write suppression
    doWrite(6'd3, 64'h0BAD_0BAD_0BAD_0BAD, 1'b1);
    check("R8", {63'h0, wFault}, 64'h0);
    doRead(6'd3); check("R8", rVal, 64'hDEAD_BEEF_0123_4567);
    doWrite(6'd45, ONES, 1'b1); check("R8", {63'h0, wFault}, 64'h0);
    doWrite(6'd47, ONES, 1'b1); check("R8", {61'h0, wStb}, 64'h0);

    // R10 control strobes
    doWrite(6'd47, 64'h0, 1'b0); check("R10", {61'h0, wStb}, 64'h1);
    @(negedge clk); #1;
    check("R10", {61'h0, cacheFlushStb, flushAsnStb, flushAllStb}, 64'h0);
    doWrite(6'd48, 64'h0, 1'b0); check("R10", {61'h0, wStb}, 64'h2);
    doWrite(6'd49, 64'h0, 1'b0); check("R10", {61'h0, wStb}, 64'h4);
    doWrite(6'd31, 64'h0, 1'b0); check("R10", {61'h0, wStb}, 64'h0);

    // R7 cycle register
    doWrite(6'd44, 64'hCAFE_F00D_1234_5678, 1'b0);
    doRead(6'd44);
    check("R7", {32'h0, rVal[63:32]}, 64'hCAFE_F00D);
    begin
      logic [31:0] lo0;
      lo0 = rVal[31:0];
      repeat (4) @(negedge clk);
      doRead(6'd44);
      check("R7", {32'h0, rVal[31:0] - lo0}, 64'd5);
      check("R7", {32'h0, rVal[63:32]}, 64'hCAFE_F00D);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule